// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This unit maps a 24-bit virtual address to a 24-bit physical address in two table lookups, both held in a byte-wide memory. The top four address bits select a segment. The next eight bits select a page inside that segment. The low twelve bits are carried through unchanged as the offset.

A register holds the base of the segment table, and a dedicated write port loads it. When a request arrives, the unit fetches the selected six-byte segment descriptor one byte per beat. The descriptor holds a page-table base, a page-table length in pages and an access right. The unit then checks the page number against the length, and the access right against the kind of access. If both checks pass, it fetches the two-byte page entry and returns the frame number joined with the offset. If either check fails, it returns a fault code and skips the page fetch.

The host raises `start` for one cycle with the address and a write flag. It then waits for the one-cycle `done` pulse.

Top module: `segpg_xlate`

## Requirements
- R1: The physical address is the 12-bit frame number from the page entry in bits 23:12 and the virtual offset (bits 11:0) in bits 11:0. Example: with segment 0 pointing at a table at 0x002000 whose third entry is 0x0003, a read of 0x002070 yields 0x003070.
- R2: The segment descriptor is read from six consecutive byte addresses starting at table base + 6 × segment (segment = VA bits 23:20). Its bytes, in address order, are: the page-table base (3 bytes, most significant first), the page-table length in pages (2 bytes, most significant first) and the access right (1 byte).
- R3: The page entry is read from two consecutive bytes at page-table base + 2 × page (page = VA bits 19:8+4, that is, bits 19:12), most significant byte first. Only its low 12 bits form the frame number; its upper 4 bits are ignored.
- R4: When the page number is not less than the page-table length, the unit reports fault code 1 (bounds) with `pa` = 0. This includes a length of 0; page length − 1 is still accepted.
- R5: Access right code 1 is read-only. A write to such a segment reports fault code 2 (protection) with `pa` = 0, and a read succeeds. Access right code 2 is read-write and allows both.
- R6: Any other access right code (0 or 3..255) means no access. Every read or write to such a segment reports fault code 2.
- R7: When a request is both out of bounds and not permitted, the bounds fault (code 1) is the one reported.
- R8: `busy` rises in the cycle after an accepted `start` and stays high through the `done` cycle. `done` is a single-cycle pulse. A `start` raised while `busy` is high is ignored and produces no further result.
- R9: After reset, `busy`, `done` and `mem_rd_en` are low.
- R10: A successful translation makes exactly 8 memory reads: 6 for the descriptor, then 2 for the page entry. A faulting one makes only the 6 descriptor reads. Within a burst, each read address is one more than the previous one.
- R11: A pulse on `stb_wr_en` loads `stb_wr_data` as the segment-table base, and later walks use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| stb_wr_en | input | 1 | Load the segment-table base register |
| stb_wr_data | input | 24 | New segment-table base |
| start | input | 1 | Begin a translation (accepted when idle) |
| va | input | 24 | Virtual address to translate |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid for this cycle |
| pa | output | 24 | Physical address (0 on a fault) |
| fault | output | 2 | 0 none, 1 bounds, 2 protection |

## Verification
The bench uses the default parameters: 4-bit segment, 8-bit page, 12-bit offset, 24-bit physical address, and bounds checked before rights. These widths allow a segment table with all sixteen descriptors, so the bench reaches segment 15. They also allow a page-table length of 256, so the bench reaches page 0xFF. The byte-wide memory model gives the bench the exact read count and address of every beat, so it can check the descriptor and page-entry layouts, the scaling of the segment and page indices, and the missing page fetch on a fault. The bench also checks the fault codes with the page number just inside and just outside the limit, and the rights when both a bounds fault and a protection fault apply.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_BOUNDS = 2'd1,
      FLT_PROT   = 2'd2
   } fault_e;

   localparam logic [7:0] RIGHT_RO = 8'd1;
   localparam logic [7:0] RIGHT_RW = 8'd2;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_SEG,
      WS_CHK,
      WS_PTE,
      WS_DONE
   } walk_st_e;

endpackage

// File: rtl/segpg_field_split.sv
module segpg_field_split #(
   parameter int SEG_W = 4,
   parameter int PG_W  = 8,
   parameter int OFF_W = 12,
   localparam int VA_W = SEG_W + PG_W + OFF_W
) (
   input  logic [VA_W-1:0]  va,
   output logic [SEG_W-1:0] seg,
   output logic [PG_W-1:0]  page,
   output logic [OFF_W-1:0] off
);

   assign seg  = va[VA_W-1 -: SEG_W];
   assign page = va[OFF_W +: PG_W];
   assign off  = va[OFF_W-1:0];

endmodule

// File: rtl/segpg_byte_gather.sv
module segpg_byte_gather #(
   parameter int NBYTES = 6,
   localparam int ACC_W = 8 * NBYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic [7:0]       byte_in,
   output logic [ACC_W-1:0] acc
);

   // Most significant byte arrives first; each beat shifts left by one byte.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (shift_en)
         acc <= {acc[ACC_W-9:0], byte_in};
   end

endmodule

// File: rtl/segpg_access_chk.sv
module segpg_access_chk
   import xlate_pkg::*;
#(
   parameter int PG_W         = 8,
   parameter int SIZE_W       = 16,
   parameter bit BOUNDS_FIRST = 1'b1
) (
   input  logic [PG_W-1:0]   page,
   input  logic [SIZE_W-1:0] size,
   input  logic [7:0]        right,
   input  logic              is_write,
   output logic [1:0]        fault
);

   logic out_of_range;
   logic denied;

   assign out_of_range = (SIZE_W'(page) >= size);
   assign denied       = !((right == RIGHT_RW) || (right == RIGHT_RO && !is_write));

   generate
      if (BOUNDS_FIRST) begin : g_bounds_first
         always_comb begin
            if (out_of_range)  fault = FLT_BOUNDS;
            else if (denied)   fault = FLT_PROT;
            else               fault = FLT_NONE;
         end
      end else begin : g_rights_first
         always_comb begin
            if (denied)             fault = FLT_PROT;
            else if (out_of_range)  fault = FLT_BOUNDS;
            else                    fault = FLT_NONE;
         end
      end
   endgenerate

endmodule

// File: rtl/segpg_xlate.sv
module segpg_xlate
   import xlate_pkg::*;
#(
   parameter int SEG_W        = 4,
   parameter int PG_W         = 8,
   parameter int OFF_W        = 12,
   parameter int PA_W         = 24,
   parameter bit BOUNDS_FIRST = 1'b1,
   localparam int VA_W        = SEG_W + PG_W + OFF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stb_wr_en,
   input  logic [PA_W-1:0] stb_wr_data,
   input  logic            start,
   input  logic [VA_W-1:0] va,
   input  logic            is_write,
   output logic            mem_rd_en,
   output logic [PA_W-1:0] mem_addr,
   input  logic [7:0]      mem_rdata,
   output logic            busy,
   output logic            done,
   output logic [PA_W-1:0] pa,
   output logic [1:0]      fault
);

   localparam int FRAME_W       = PA_W - OFF_W;
   localparam int ADDR_BYTES    = (PA_W + 7) / 8;
   localparam int SIZE_BYTES    = 2;
   localparam int SIZE_W        = 8 * SIZE_BYTES;
   localparam int SEG_ENT_BYTES = ADDR_BYTES + SIZE_BYTES + 1;
   localparam int PTE_BYTES     = (FRAME_W + 7) / 8;
   localparam int ACC_W         = 8 * SEG_ENT_BYTES;
   localparam int CNT_W         = $clog2(SEG_ENT_BYTES + 1);

   generate
      if (FRAME_W < 1) begin : g_bad_frame
         $error("segpg_xlate: PA_W must exceed OFF_W");
      end
      if (PG_W >= SIZE_W) begin : g_bad_page
         $error("segpg_xlate: PG_W must be below the length field width");
      end
      if (PTE_BYTES > SEG_ENT_BYTES) begin : g_bad_pte
         $error("segpg_xlate: page entry wider than gather buffer");
      end
      if (SEG_W < 1 || OFF_W < 1) begin : g_bad_fields
         $error("segpg_xlate: empty address field");
      end
   endgenerate

   walk_st_e              st_q;
   logic [PA_W-1:0]       stb_base_q;
   logic [VA_W-1:0]       va_q;
   logic                  wr_q;
   logic [PA_W-1:0]       pt_base_q;
   logic [1:0]            fault_q;
   logic [CNT_W-1:0]      issue_cnt;
   logic [CNT_W-1:0]      cap_cnt;
   logic                  cap_q;

   logic [SEG_W-1:0]      seg_f;
   logic [PG_W-1:0]       page_f;
   logic [OFF_W-1:0]      off_f;
   logic [ACC_W-1:0]      acc;
   logic                  gather_clr;
   logic [1:0]            chk_fault;

   logic [PA_W-1:0]       seg_ent_addr;
   logic [PA_W-1:0]       pte_addr;
   logic [PA_W-1:0]       burst_base;
   logic [PA_W-1:0]       desc_base;
   logic [SIZE_W-1:0]     desc_size;
   logic [7:0]            desc_right;
   logic [CNT_W-1:0]      burst_len;
   logic                  last_cap;

   segpg_field_split #(
      .SEG_W (SEG_W),
      .PG_W  (PG_W),
      .OFF_W (OFF_W)
   ) u_split (
      .va   (va_q),
      .seg  (seg_f),
      .page (page_f),
      .off  (off_f)
   );

   segpg_byte_gather #(
      .NBYTES (SEG_ENT_BYTES)
   ) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (gather_clr),
      .shift_en (cap_q),
      .byte_in  (mem_rdata),
      .acc      (acc)
   );

   // Descriptor fields, most significant byte first.
   logic [8*ADDR_BYTES-1:0] desc_base_raw;
   assign desc_base_raw = acc[ACC_W-1 -: 8*ADDR_BYTES];
   assign desc_base     = desc_base_raw[PA_W-1:0];
   assign desc_size     = acc[8 +: SIZE_W];
   assign desc_right    = acc[7:0];

   segpg_access_chk #(
      .PG_W         (PG_W),
      .SIZE_W       (SIZE_W),
      .BOUNDS_FIRST (BOUNDS_FIRST)
   ) u_chk (
      .page     (page_f),
      .size     (desc_size),
      .right    (desc_right),
      .is_write (wr_q),
      .fault    (chk_fault)
   );

   assign seg_ent_addr = stb_base_q + PA_W'(seg_f) * PA_W'(SEG_ENT_BYTES);
   assign pte_addr     = pt_base_q + (PA_W'(page_f) << 1);
   assign burst_base   = (st_q == WS_SEG) ? seg_ent_addr : pte_addr;
   assign burst_len    = (st_q == WS_SEG) ? CNT_W'(SEG_ENT_BYTES) : CNT_W'(PTE_BYTES);

   assign mem_rd_en  = ((st_q == WS_SEG) || (st_q == WS_PTE)) && (issue_cnt < burst_len);
   assign mem_addr   = burst_base + PA_W'(issue_cnt);
   assign last_cap   = cap_q && (cap_cnt == burst_len - CNT_W'(1));
   assign gather_clr = (st_q == WS_IDLE && start) || (st_q == WS_CHK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stb_base_q <= '0;
      else if (stb_wr_en)
         stb_base_q <= stb_wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= WS_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         pt_base_q <= '0;
         fault_q   <= FLT_NONE;
         issue_cnt <= '0;
         cap_cnt   <= '0;
         cap_q     <= 1'b0;
      end else begin
         cap_q <= mem_rd_en;
         if (mem_rd_en)
            issue_cnt <= issue_cnt + CNT_W'(1);
         if (cap_q)
            cap_cnt <= cap_cnt + CNT_W'(1);
         unique case (st_q)
            WS_IDLE: begin
               if (start) begin
                  va_q      <= va;
                  wr_q      <= is_write;
                  fault_q   <= FLT_NONE;
                  issue_cnt <= '0;
                  cap_cnt   <= '0;
                  st_q      <= WS_SEG;
               end
            end
            WS_SEG: begin
               if (last_cap)
                  st_q <= WS_CHK;
            end
            WS_CHK: begin
               issue_cnt <= '0;
               cap_cnt   <= '0;
               fault_q   <= chk_fault;
               pt_base_q <= desc_base;
               st_q      <= (chk_fault == FLT_NONE) ? WS_PTE : WS_DONE;
            end
            WS_PTE: begin
               if (last_cap)
                  st_q <= WS_DONE;
            end
            WS_DONE: begin
               st_q <= WS_IDLE;
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign busy  = (st_q != WS_IDLE);
   assign done  = (st_q == WS_DONE);
   assign fault = done ? fault_q : FLT_NONE;
   assign pa    = (done && fault_q == FLT_NONE) ? {acc[FRAME_W-1:0], off_f} : '0;

endmodule

// File: rtl/segpg_xlate_chk.sv
module segpg_xlate_chk #(
   parameter int PA_W = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [1:0]      fault,
   input logic [PA_W-1:0] pa,
   input logic            mem_rd_en,
   input logic [PA_W-1:0] mem_addr
);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R8
   start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8
   busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R4
   fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault != 2'd0) |-> (pa == '0));

   // R5
   fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault != 2'd3));

   // R10
   idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en);

   // R10
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + PA_W'(1)));

endmodule

bind segpg_xlate segpg_xlate_chk #(.PA_W(PA_W)) u_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .fault     (fault),
   .pa        (pa),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr)
);

// File: tb/segpg_xlate_tb_top.sv
module segpg_xlate_tb_top;

   logic        clk;
   logic        rst_n;
   logic        stb_wr_en;
   logic [23:0] stb_wr_data;
   logic        start;
   logic [23:0] va;
   logic        is_write;
   logic        mem_rd_en;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        busy;
   logic        done;
   logic [23:0] pa;
   logic [1:0]  fault;

   int vectors;
   int miscompares;
   int cycles;
   int rd_count;
   bit prev_done;

   typedef struct {
      logic [23:0] pa;
      logic [1:0]  fault;
      int          reads;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   logic [7:0] mem [int];

   segpg_xlate dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb_wr_en   (stb_wr_en),
      .stb_wr_data (stb_wr_data),
      .start       (start),
      .va          (va),
      .is_write    (is_write),
      .mem_rd_en   (mem_rd_en),
      .mem_addr    (mem_addr),
      .mem_rdata   (mem_rdata),
      .busy        (busy),
      .done        (done),
      .pa          (pa),
      .fault       (fault)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   // byte memory, one-cycle read latency
   always @(posedge clk) begin
      if (mem_rd_en)
         mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
   end

   function automatic void put_seg(input logic [23:0] tbl, input int seg,
                                   input logic [23:0] base, input logic [15:0] len,
                                   input logic [7:0] right);
      int a;
      a = int'(tbl) + 6 * seg;
      mem[a]     = base[23:16];
      mem[a + 1] = base[15:8];
      mem[a + 2] = base[7:0];
      mem[a + 3] = len[15:8];
      mem[a + 4] = len[7:0];
      mem[a + 5] = right;
   endfunction

   function automatic void put_pte(input logic [23:0] ptb, input int pg, input logic [15:0] v);
      mem[int'(ptb) + 2 * pg]     = v[15:8];
      mem[int'(ptb) + 2 * pg + 1] = v[7:0];
   endfunction

   // monitor: counts reads, pops the scoreboard on every result
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) rd_count++;
         if (done) begin
            if (prev_done) begin
               vectors++; miscompares++;
               $display("FAIL R8 done wider than one cycle: actual 2+ cycles expected 1");
            end
            if (sb_q.size() == 0) begin
               vectors++; miscompares++;
               $display("FAIL R8 unexpected result pa=%h fault=%0d expected none", pa, fault);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               vectors++;
               if (pa !== e.pa || fault !== e.fault) begin
                  miscompares++;
                  $display("FAIL %s: actual pa=%h fault=%0d expected pa=%h fault=%0d",
                           e.tag, pa, fault, e.pa, e.fault);
               end
               vectors++;
               if (rd_count != e.reads) begin
                  miscompares++;
                  $display("FAIL R10 %s reads: actual %0d expected %0d", e.tag, rd_count, e.reads);
               end
            end
            rd_count = 0;
         end
         prev_done = done;
      end
   end

   task automatic run_xlate(input logic [23:0] a, input bit wr, input logic [23:0] epa,
                            input logic [1:0] eflt, input string tag, input bit dup);
      exp_t e;
      e.pa = epa; e.fault = eflt; e.reads = (eflt == 2'd0) ? 8 : 6; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      start = 1'b1; va = a; is_write = wr;
      @(negedge clk);
      start = 1'b0;
      if (dup) begin
         repeat (2) @(negedge clk);
         start = 1'b1; va = a ^ 24'h100000; is_write = ~wr;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      vectors++;
      if (sb_q.size() != 0) begin
         miscompares++;
         $display("FAIL R8 %s: actual %0d results pending expected 0", tag, sb_q.size());
         sb_q.delete();
      end
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         miscompares++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      vectors = 0; miscompares = 0; cycles = 0; rd_count = 0; prev_done = 1'b0;
      rst_n = 1'b0; stb_wr_en = 1'b0; stb_wr_data = '0; start = 1'b0; va = '0; is_write = 1'b0;

      // tables: segment table at 0x000100
      put_seg(24'h000100, 0,  24'h002000, 16'h0014, 8'h01);
      put_seg(24'h000100, 1,  24'h004000, 16'h0010, 8'h00);
      put_seg(24'h000100, 2,  24'h001000, 16'h000D, 8'h02);
      put_seg(24'h000100, 3,  24'h005000, 16'h0000, 8'h01);
      put_seg(24'h000100, 4,  24'h006000, 16'h0010, 8'h03);
      put_seg(24'h000100, 15, 24'h00F000, 16'h0100, 8'h02);
      put_pte(24'h002000, 0, 16'h0013);
      put_pte(24'h002000, 1, 16'h002A);
      put_pte(24'h002000, 2, 16'h0003);
      put_pte(24'h001000, 12, 16'h0456);
      put_pte(24'h00F000, 255, 16'hFABC);
      // alternate table at 0x000400
      put_seg(24'h000400, 0, 24'h003000, 16'h0001, 8'h02);
      put_pte(24'h003000, 0, 16'h0777);

      repeat (3) @(negedge clk);
      // R9 reset state
      vectors++;
      if (busy !== 1'b0 || done !== 1'b0 || mem_rd_en !== 1'b0) begin
         miscompares++;
         $display("FAIL R9 reset: actual busy=%b done=%b rd=%b expected 0 0 0", busy, done, mem_rd_en);
      end
      rst_n = 1'b1;
      @(negedge clk);
      stb_wr_en = 1'b1; stb_wr_data = 24'h000100;   // R11 load base
      @(negedge clk);
      stb_wr_en = 1'b0;

      run_xlate(24'h002070, 1'b0, 24'h003070, 2'd0, "R1 worked read", 1'b0);
      run_xlate(24'h001ABC, 1'b0, 24'h02AABC, 2'd0, "R1 page 1 read", 1'b0);
      run_xlate(24'h002070, 1'b1, 24'h000000, 2'd2, "R5 write read-only", 1'b0);
      run_xlate(24'h210014, 1'b1, 24'h000000, 2'd1, "R4 page over length", 1'b0);
      run_xlate(24'h20C123, 1'b1, 24'h456123, 2'd0, "R4 last page in range R3", 1'b0);
      run_xlate(24'h100004, 1'b0, 24'h000000, 2'd2, "R6 right none read", 1'b0);
      run_xlate(24'h400004, 1'b1, 24'h000000, 2'd2, "R6 right code 3 write", 1'b0);
      run_xlate(24'h300000, 1'b1, 24'h000000, 2'd1, "R7 bounds over rights", 1'b0);
      run_xlate(24'hFFF001, 1'b1, 24'hABC001, 2'd0, "R2 segment 15 R3 upper bits", 1'b0);
      run_xlate(24'h002070, 1'b0, 24'h003070, 2'd0, "R8 start while busy ignored", 1'b1);

      @(negedge clk);
      stb_wr_en = 1'b1; stb_wr_data = 24'h000400;
      @(negedge clk);
      stb_wr_en = 1'b0;
      run_xlate(24'h000005, 1'b1, 24'h777005, 2'd0, "R11 relocated table", 1'b0);
      run_xlate(24'h001005, 1'b0, 24'h000000, 2'd1, "R11 relocated length", 1'b0);

      finish_run();
   end

endmodule